// File: doc/BRIEF.md
# Interleaved Two-Factor Path Stepper

This block advances a batch of simulated asset paths under a stochastic-volatility model. Each path keeps a log-price, a variance and an alive flag. The paths are updated one time step at a time. Every accepted cycle supplies two Gaussian samples: one moves the log-price and one moves the variance. The block updates the paths in rotation, one slot per accepted sample. Each slot takes exactly one step per pass, and the slots go strictly in order. A slot is read again only once its previous result has come out of the update pipeline. The number of slots is therefore the same as the pipeline latency, so the datapath never stalls on its own results.

The log-price update is an Euler step with full truncation: a negative variance counts as zero in the drift and diffusion terms. All arithmetic is signed fixed point. A path is knocked out for good if its log-price reaches either barrier of a double-barrier band after any step. A coarse mode steps each path with the sum of two consecutive samples, which serves a lower simulation level. Model parameters come from a small register file that is locked while a batch runs.

When the last pass has been written back, a done pulse marks the start of an ordered dump. The dump presents one slot per cycle, with that slot's terminal log-price, variance and alive flag.

Top module: `psv_path_stepper`

## Requirements
- R1: A start pulse while idle loads every slot with the initial log-price (register 8), the initial variance (register 9) and alive = 1, and sets busy in the next cycle. A start pulse while busy has no effect.
- R2: A sample pair is consumed only in a cycle where z_valid is high and a batch is running. Slots are served 0, 1, ..., NUM_SLOTS-1 and then again from 0, each taking one step per pass. z_valid while idle changes nothing.
- R3: A fine step uses mul(a,b) = (a*b) >>> FRAC (floor), truncated to W bits, and s = floor(sqrt(vp << FRAC)) with vp = max(v,0). It computes x' = x + reg0 - mul(vp,reg1) + mul(mul(s,reg2),zp) and v' = v + mul(reg3, reg4 - vp) + mul(mul(reg5,s),zv). All sums wrap at W bits, and samples are signed Q(FRAC).
- R4: Full truncation: when the variance is negative, the step gives x' = x + reg0 and v' = v + mul(reg3, reg4).
- R5: After each step the alive flag is cleared if x' >= register 6 or x' <= register 7 (signed). Once cleared it stays cleared for the rest of the batch, while log-price and variance keep updating.
- R6: When register 11 is nonzero (coarse mode), a batch runs 2*steps passes. In the even passes the slot only stores its samples. In the odd passes the slot steps with the sum of the stored sample and the current sample, for each of the two factors.
- R7: done is high for exactly one cycle: the first dump cycle, when out_slot is 0. This happens after every pass of every slot has been written back. A steps value (register 10) of 0 behaves as 1.
- R8: The dump holds out_valid for NUM_SLOTS consecutive cycles with out_slot counting up from 0 and the slot's terminal values. After the dump, busy returns low.
- R9: Configuration writes go to registers 0 to 11, addressed as in R3 to R7. A write while busy is ignored.
- R10: After reset, busy, done and out_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | CFG_AW | Configuration register index |
| cfg_wdata | input | W | Configuration write data |
| start | input | 1 | Begin a batch |
| z_valid | input | 1 | Sample pair present |
| z_price | input | ZW | Signed Gaussian sample for the log-price |
| z_var | input | ZW | Signed Gaussian sample for the variance |
| busy | output | 1 | Batch in progress (run, drain or dump) |
| done | output | 1 | One-cycle completion pulse |
| out_valid | output | 1 | Dump entry valid |
| out_slot | output | $clog2(NUM_SLOTS) | Slot index of the dump entry |
| out_price | output | W | Terminal log-price |
| out_var | output | W | Terminal variance |
| out_alive | output | 1 | Slot survived both barriers |

## Verification
The hardest condition to reach is a slot whose variance is negative when it is read. Only then is the truncation path taken, and it arises from random-looking samples only occasionally. The stimulus reaches it directly by loading a negative initial variance, and the expected values then reduce to a closed form. Knock-out persistence needs paths that cross a barrier and may wander back. Tight barriers with several steps produce a mix of dead and surviving slots. Configuration writes and a second start are injected in the middle of a run to show that both are ignored.

// File: rtl/psv_pkg.sv
package psv_pkg;
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_RUN   = 2'd1,
        PH_DRAIN = 2'd2,
        PH_DUMP  = 2'd3
    } phase_e;

    localparam int NUM_CFG  = 12;
    localparam int CFG_MU   = 0;
    localparam int CFG_HDT  = 1;
    localparam int CFG_SQDT = 2;
    localparam int CFG_KAP  = 3;
    localparam int CFG_THE  = 4;
    localparam int CFG_XI   = 5;
    localparam int CFG_UP   = 6;
    localparam int CFG_LO   = 7;
    localparam int CFG_X0   = 8;
    localparam int CFG_V0   = 9;
    localparam int CFG_STEP = 10;
    localparam int CFG_MODE = 11;
endpackage

// File: rtl/psv_cfg_regs.sv
module psv_cfg_regs #(
    parameter int W  = 24,
    parameter int AW = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  lock,
    input  logic                  we,
    input  logic [AW-1:0]         addr,
    input  logic [W-1:0]          wdata,
    output logic [psv_pkg::NUM_CFG*W-1:0] flat
);
    import psv_pkg::*;

    logic [W-1:0] regs_q [NUM_CFG];
    logic [W-1:0] regs_d [NUM_CFG];

    always_comb begin
        for (int i = 0; i < NUM_CFG; i++) regs_d[i] = regs_q[i];
        if (we && !lock && (int'(addr) < NUM_CFG)) regs_d[int'(addr)] = wdata;
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_CFG; i++) begin
            if (!rst_n) regs_q[i] <= '0;
            else        regs_q[i] <= regs_d[i];
        end
    end

    for (genvar g = 0; g < NUM_CFG; g++) begin : g_flat
        assign flat[g*W +: W] = regs_q[g];
    end

    a_r9_locked_cfg_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (lock && we) |=> $stable(flat));
endmodule

// File: rtl/psv_step_math.sv
module psv_step_math #(
    parameter int W    = 24,
    parameter int FRAC = 12
) (
    input  logic signed [W-1:0] x_i,
    input  logic signed [W-1:0] v_i,
    input  logic                alive_i,
    input  logic signed [W-1:0] zx_i,
    input  logic signed [W-1:0] zv_i,
    input  logic signed [W-1:0] mu_i,
    input  logic signed [W-1:0] hdt_i,
    input  logic signed [W-1:0] sqdt_i,
    input  logic signed [W-1:0] kap_i,
    input  logic signed [W-1:0] theta_i,
    input  logic signed [W-1:0] xi_i,
    input  logic signed [W-1:0] upper_i,
    input  logic signed [W-1:0] lower_i,
    output logic signed [W-1:0] x_o,
    output logic signed [W-1:0] v_o,
    output logic                alive_o
);
    localparam int NW = W + FRAC;
    localparam int RW = (NW + 1) / 2;
    localparam int SW = 2 * RW;
    localparam int AW = SW + 2;

    function automatic logic signed [W-1:0] mulq(input logic signed [W-1:0] a,
                                                 input logic signed [W-1:0] b);
        logic signed [2*W-1:0] p;
        p = (2*W)'(a) * (2*W)'(b);
        return p[FRAC +: W];
    endfunction

    function automatic logic [RW-1:0] isqrt(input logic [NW-1:0] n);
        logic [RW-1:0] r;
        logic [SW-1:0] t;
        r = '0;
        for (int i = RW - 1; i >= 0; i--) begin
            r[i] = 1'b1;
            t = SW'(r) * SW'(r);
            if (t > SW'(n)) r[i] = 1'b0;
        end
        return r;
    endfunction

    logic signed [W-1:0] vp, sv;
    logic [NW-1:0]       rad;
    logic [RW-1:0]       root;

    assign vp   = v_i[W-1] ? '0 : v_i;
    assign rad  = {vp, {FRAC{1'b0}}};
    assign root = isqrt(rad);
    assign sv   = W'(root);

    assign x_o = x_i + mu_i - mulq(vp, hdt_i) + mulq(mulq(sv, sqdt_i), zx_i);
    assign v_o = v_i + mulq(kap_i, theta_i - vp) + mulq(mulq(xi_i, sv), zv_i);
    assign alive_o = alive_i && (x_o < upper_i) && (x_o > lower_i);

    always_comb begin
        if (!$isunknown(rad)) begin
            a_r3_root_floor: assert ((AW'(root) * AW'(root) <= AW'(rad)) &&
                                     ((AW'(root) + 1) * (AW'(root) + 1) > AW'(rad)));
        end
    end
endmodule

// File: rtl/psv_pipe.sv
module psv_pipe #(
    parameter int DW    = 8,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);
    logic [DW-1:0] stg_q [DEPTH];
    logic [DW-1:0] stg_d [DEPTH];

    always_comb begin
        stg_d[0] = din;
        for (int k = 1; k < DEPTH; k++) stg_d[k] = stg_q[k-1];
    end

    always_ff @(posedge clk) begin
        for (int k = 0; k < DEPTH; k++) begin
            if (!rst_n) stg_q[k] <= '0;
            else        stg_q[k] <= stg_d[k];
        end
    end

    assign dout = stg_q[DEPTH-1];
endmodule

// File: rtl/psv_path_stepper.sv
module psv_path_stepper #(
    parameter int NUM_SLOTS = 60,
    parameter int W         = 24,
    parameter int ZW        = 16,
    parameter int FRAC      = 12,
    parameter int CFG_AW    = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cfg_we,
    input  logic [CFG_AW-1:0]            cfg_addr,
    input  logic [W-1:0]                 cfg_wdata,
    input  logic                         start,
    input  logic                         z_valid,
    input  logic [ZW-1:0]                z_price,
    input  logic [ZW-1:0]                z_var,
    output logic                         busy,
    output logic                         done,
    output logic                         out_valid,
    output logic [$clog2(NUM_SLOTS)-1:0] out_slot,
    output logic [W-1:0]                 out_price,
    output logic [W-1:0]                 out_var,
    output logic                         out_alive
);
    import psv_pkg::*;

    localparam int SW   = $clog2(NUM_SLOTS);
    localparam int PIPE = NUM_SLOTS - 1;
    localparam int DW   = 1 + SW + 2 * W + 1;

    typedef struct packed {
        phase_e        phase;
        logic [SW-1:0] slot;
        logic [W:0]    pass;
        logic [SW-1:0] cnt;
        logic          done;
    } ctl_t;

    ctl_t ctl_q, ctl_d;
    logic signed [W-1:0]  x_q [NUM_SLOTS];
    logic signed [W-1:0]  x_d [NUM_SLOTS];
    logic signed [W-1:0]  v_q [NUM_SLOTS];
    logic signed [W-1:0]  v_d [NUM_SLOTS];
    logic signed [ZW:0]   zsx_q [NUM_SLOTS];
    logic signed [ZW:0]   zsx_d [NUM_SLOTS];
    logic signed [ZW:0]   zsv_q [NUM_SLOTS];
    logic signed [ZW:0]   zsv_d [NUM_SLOTS];
    logic [NUM_SLOTS-1:0] alive_q, alive_d;

    logic [NUM_CFG*W-1:0] cfg;
    logic signed [W-1:0]  c_up, c_lo, c_x0, c_v0, c_steps;
    logic                 coarse;

    psv_cfg_regs #(.W(W), .AW(CFG_AW)) u_cfg (
        .clk(clk), .rst_n(rst_n), .lock(busy), .we(cfg_we),
        .addr(cfg_addr), .wdata(cfg_wdata), .flat(cfg));

    assign c_up    = cfg[CFG_UP*W +: W];
    assign c_lo    = cfg[CFG_LO*W +: W];
    assign c_x0    = cfg[CFG_X0*W +: W];
    assign c_v0    = cfg[CFG_V0*W +: W];
    assign c_steps = cfg[CFG_STEP*W +: W];
    assign coarse  = |cfg[CFG_MODE*W +: W];

    // Issue-side decode
    logic              run, first_half, upd, last_pass;
    logic [W:0]        total;
    logic signed [ZW-1:0] zp, zv;
    logic signed [ZW:0]   zx1, zv1;
    logic signed [W-1:0]  zx_w, zv_w, xn, vn;
    logic                 aln;

    assign run        = (ctl_q.phase == PH_RUN) && z_valid;
    assign first_half = coarse && !ctl_q.pass[0];
    assign upd        = run && !first_half;
    assign total      = ((c_steps == '0) ? (W+1)'(1) : {1'b0, c_steps}) << coarse;
    assign last_pass  = (ctl_q.pass == total - 1'b1);
    assign zp   = z_price;
    assign zv   = z_var;
    assign zx1  = coarse ? (zsx_q[ctl_q.slot] + (ZW+1)'(zp)) : (ZW+1)'(zp);
    assign zv1  = coarse ? (zsv_q[ctl_q.slot] + (ZW+1)'(zv)) : (ZW+1)'(zv);
    assign zx_w = W'(zx1);
    assign zv_w = W'(zv1);

    psv_step_math #(.W(W), .FRAC(FRAC)) u_math (
        .x_i(x_q[ctl_q.slot]), .v_i(v_q[ctl_q.slot]), .alive_i(alive_q[ctl_q.slot]),
        .zx_i(zx_w), .zv_i(zv_w),
        .mu_i(cfg[CFG_MU*W +: W]), .hdt_i(cfg[CFG_HDT*W +: W]),
        .sqdt_i(cfg[CFG_SQDT*W +: W]), .kap_i(cfg[CFG_KAP*W +: W]),
        .theta_i(cfg[CFG_THE*W +: W]), .xi_i(cfg[CFG_XI*W +: W]),
        .upper_i(c_up), .lower_i(c_lo),
        .x_o(xn), .v_o(vn), .alive_o(aln));

    // Latency line: the result returns exactly when the slot is read again
    logic [DW-1:0]       pipe_in, pipe_out;
    logic                wb_valid, wb_alive;
    logic [SW-1:0]       wb_slot;
    logic signed [W-1:0] wb_x, wb_v;

    assign pipe_in = {upd, ctl_q.slot, xn, vn, aln};
    psv_pipe #(.DW(DW), .DEPTH(PIPE)) u_pipe (
        .clk(clk), .rst_n(rst_n), .din(pipe_in), .dout(pipe_out));
    assign {wb_valid, wb_slot, wb_x, wb_v, wb_alive} = pipe_out;

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        x_d = x_q; v_d = v_q; zsx_d = zsx_q; zsv_d = zsv_q; alive_d = alive_q;
        unique case (ctl_q.phase)
            PH_IDLE: if (start) begin
                for (int s = 0; s < NUM_SLOTS; s++) begin
                    x_d[s] = c_x0; v_d[s] = c_v0; zsx_d[s] = '0; zsv_d[s] = '0;
                end
                alive_d     = '1;
                ctl_d.phase = PH_RUN;
                ctl_d.slot  = '0;
                ctl_d.pass  = '0;
            end
            PH_RUN: if (z_valid) begin
                if (first_half) begin
                    zsx_d[ctl_q.slot] = (ZW+1)'(zp);
                    zsv_d[ctl_q.slot] = (ZW+1)'(zv);
                end
                if (ctl_q.slot == SW'(NUM_SLOTS - 1)) begin
                    ctl_d.slot = '0;
                    if (last_pass) begin
                        ctl_d.phase = PH_DRAIN;
                        ctl_d.cnt   = '0;
                    end else begin
                        ctl_d.pass = ctl_q.pass + 1'b1;
                    end
                end else begin
                    ctl_d.slot = ctl_q.slot + 1'b1;
                end
            end
            PH_DRAIN: if (ctl_q.cnt == SW'(PIPE - 1)) begin
                ctl_d.phase = PH_DUMP;
                ctl_d.cnt   = '0;
                ctl_d.done  = 1'b1;
            end else begin
                ctl_d.cnt = ctl_q.cnt + 1'b1;
            end
            PH_DUMP: if (ctl_q.cnt == SW'(NUM_SLOTS - 1)) ctl_d.phase = PH_IDLE;
                     else ctl_d.cnt = ctl_q.cnt + 1'b1;
            default: ctl_d.phase = PH_IDLE;
        endcase
        if (wb_valid) begin
            x_d[wb_slot]     = wb_x;
            v_d[wb_slot]     = wb_v;
            alive_d[wb_slot] = wb_alive;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q   <= '{phase: PH_IDLE, default: '0};
            alive_q <= '0;
            for (int s = 0; s < NUM_SLOTS; s++) begin
                x_q[s] <= '0; v_q[s] <= '0; zsx_q[s] <= '0; zsv_q[s] <= '0;
            end
        end else begin
            ctl_q   <= ctl_d;
            alive_q <= alive_d;
            for (int s = 0; s < NUM_SLOTS; s++) begin
                x_q[s] <= x_d[s]; v_q[s] <= v_d[s]; zsx_q[s] <= zsx_d[s]; zsv_q[s] <= zsv_d[s];
            end
        end
    end

    assign busy      = (ctl_q.phase != PH_IDLE);
    assign done      = ctl_q.done;
    assign out_valid = (ctl_q.phase == PH_DUMP);
    assign out_slot  = ctl_q.cnt;
    assign out_price = x_q[ctl_q.cnt];
    assign out_var   = v_q[ctl_q.cnt];
    assign out_alive = alive_q[ctl_q.cnt];

    a_r1_all_alive: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.phase == PH_IDLE && start) |=> (busy && $countones(alive_q) == NUM_SLOTS));
    a_r2_hold_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.phase == PH_RUN && !z_valid) |=> $stable(ctl_q.slot));
    a_r5_sticky_ko: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && !alive_q[wb_slot]) |-> !wb_alive);
    a_r7_done_first: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (out_valid && out_slot == '0));
    a_r8_slot_order: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_slot != SW'(NUM_SLOTS - 1)) |=>
        (out_valid && out_slot == $past(out_slot) + 1'b1));
endmodule

// File: tb/tb_psv_path_stepper.sv
module tb_psv_path_stepper;
    localparam int CLK_PERIOD = 10;
    localparam int N    = 60;
    localparam int W    = 24;
    localparam int ZW   = 16;
    localparam int FRAC = 12;
    localparam int SW   = $clog2(N);

    logic clk = 1'b0, rst_n = 1'b0;
    logic cfg_we = 1'b0, start = 1'b0, z_valid = 1'b0;
    logic [3:0] cfg_addr = '0;
    logic [W-1:0] cfg_wdata = '0;
    logic [ZW-1:0] z_price = '0, z_var = '0;
    logic busy, done, out_valid, out_alive;
    logic [SW-1:0] out_slot;
    logic [W-1:0] out_price, out_var;

    int n_checks = 0, n_fail = 0;
    longint c [12];
    longint rx [N], rv [N];
    bit     ral [N];
    longint rzx [N], rzv [N];
    longint dx [N], dv [N];

    always #(CLK_PERIOD/2) clk = ~clk;

    psv_path_stepper #(.NUM_SLOTS(N), .W(W), .ZW(ZW), .FRAC(FRAC), .CFG_AW(4)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .start(start), .z_valid(z_valid),
        .z_price(z_price), .z_var(z_var), .busy(busy), .done(done),
        .out_valid(out_valid), .out_slot(out_slot), .out_price(out_price),
        .out_var(out_var), .out_alive(out_alive));

    task automatic check(string req, string what, longint act, longint exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic longint tr(longint p);
        longint m;
        m = p & ((longint'(1) << W) - 1);
        if (m >= (longint'(1) << (W - 1))) m -= (longint'(1) << W);
        return m;
    endfunction

    function automatic longint mq(longint a, longint b);
        return tr((a * b) >>> FRAC);
    endfunction

    function automatic longint root_ref(longint n);
        longint lo = 0, hi = longint'(1) << 19, mid;
        while (lo < hi) begin
            mid = (lo + hi + 1) / 2;
            if (mid * mid <= n) lo = mid; else hi = mid - 1;
        end
        return lo;
    endfunction

    function automatic longint zgen(int seed, int p, int s);
        longint t = longint'((seed * 131 + p * 29 + s * 53) % 23);
        return (t - 11) * 280;
    endfunction

    task automatic step_ref(int s, longint zx, longint zv);
        longint vp, sv, nx, nv;
        vp = (rv[s] < 0) ? 0 : rv[s];
        sv = root_ref(vp << FRAC);
        nx = tr(rx[s] + c[0] - mq(vp, c[1]) + mq(mq(sv, c[2]), zx));
        nv = tr(rv[s] + mq(c[3], tr(c[4] - vp)) + mq(mq(c[5], sv), zv));
        ral[s] = ral[s] && (nx < c[6]) && (nx > c[7]);
        rx[s] = nx;
        rv[s] = nv;
    endtask

    task automatic cfg_write(int a, longint v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = v[W-1:0];
        c[a] = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic setup(longint up, longint lo, longint x0, longint v0, longint steps, longint mode);
        cfg_write(0, 12);   cfg_write(1, 256); cfg_write(2, 1024);
        cfg_write(3, 512);  cfg_write(4, 164); cfg_write(5, 512);
        cfg_write(6, up);   cfg_write(7, lo);  cfg_write(8, x0);
        cfg_write(9, v0);   cfg_write(10, steps); cfg_write(11, mode);
    endtask

    // Runs one batch, compares every dumped slot with the reference model.
    task automatic run_batch(int seed, bit stall, bit poke, string req);
        int passes;
        bit crs;
        crs = (c[11] != 0);
        passes = int'((c[10] == 0) ? 1 : c[10]) * (crs ? 2 : 1);
        for (int s = 0; s < N; s++) begin
            rx[s] = c[8]; rv[s] = c[9]; ral[s] = 1'b1; rzx[s] = 0; rzv[s] = 0;
        end
        for (int p = 0; p < passes; p++) begin
            for (int s = 0; s < N; s++) begin
                if (crs && (p % 2 == 0)) begin
                    rzx[s] = zgen(seed, p, s); rzv[s] = zgen(seed + 7, p, s);
                end else if (crs) begin
                    step_ref(s, rzx[s] + zgen(seed, p, s), rzv[s] + zgen(seed + 7, p, s));
                end else begin
                    step_ref(s, zgen(seed, p, s), zgen(seed + 7, p, s));
                end
            end
        end
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int p = 0; p < passes; p++) begin
            for (int s = 0; s < N; s++) begin
                if (stall && (s % 7 == 3)) begin
                    z_valid = 1'b0; z_price = 16'h7fff; z_var = 16'h7fff;
                    @(negedge clk);
                end
                z_valid = 1'b1;
                z_price = 16'(zgen(seed, p, s));
                z_var   = 16'(zgen(seed + 7, p, s));
                if (poke && p == 1 && s == 0) begin
                    cfg_we = 1'b1; cfg_addr = 4'd6; cfg_wdata = 24'(-1000); start = 1'b1;
                end
                @(negedge clk);
                cfg_we = 1'b0; start = 1'b0;
            end
        end
        z_valid = 1'b0;
        for (int k = 0; k < 300; k++) begin
            if (out_valid) break;
            @(negedge clk);
        end
        check("R7", "done with first dump entry", longint'(done), 1);
        for (int s = 0; s < N; s++) begin
            check("R8", "out_valid", longint'(out_valid), 1);
            check("R8", "slot order", longint'(out_slot), longint'(s));
            check(req, "price", longint'($signed(out_price)), rx[s]);
            check(req, "variance", longint'($signed(out_var)), rv[s]);
            check("R5", "alive", longint'(out_alive), longint'(ral[s]));
            dx[s] = longint'($signed(out_price));
            dv[s] = longint'($signed(out_var));
            @(negedge clk);
            if (s == 0) check("R7", "done one cycle", longint'(done), 0);
        end
        check("R8", "busy low after dump", longint'(busy), 0);
    endtask

    task automatic t_reset;
        check("R10", "busy", longint'(busy), 0);
        check("R10", "done", longint'(done), 0);
        check("R10", "out_valid", longint'(out_valid), 0);
    endtask

    task automatic t_fine;
        setup(longint'(1) << 22, -(longint'(1) << 22), 0, 164, 6, 0);
        // R2: samples offered while idle must be ignored
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            z_valid = 1'b1; z_price = 16'h1234; z_var = 16'h4321;
        end
        @(negedge clk);
        z_valid = 1'b0;
        check("R2", "idle after stray samples", longint'(busy), 0);
        run_batch(1, 1'b0, 1'b0, "R3");
    endtask

    task automatic t_knock;
        int na = 0, nr = 0;
        setup(300, -300, 0, 164, 8, 0);
        run_batch(2, 1'b0, 1'b0, "R5");
        for (int s = 0; s < N; s++) begin
            nr += int'(ral[s]);
        end
        na = nr;
        check("R5", "reference mix has survivors and knock-outs", longint'(na > 0 && na < N), 1);
    endtask

    task automatic t_coarse;
        setup(longint'(1) << 22, -(longint'(1) << 22), 100, 164, 4, 1);
        run_batch(3, 1'b1, 1'b0, "R6");
    endtask

    task automatic t_trunc;
        setup(longint'(1) << 22, -(longint'(1) << 22), 0, -200, 1, 0);
        run_batch(4, 1'b0, 1'b0, "R4");
        check("R4", "truncated log-price slot0", dx[0], c[8] + c[0]);
        check("R4", "truncated variance slot0", dv[0], -200 + mq(c[3], c[4]));
        check("R4", "truncated log-price last slot", dx[N-1], c[8] + c[0]);
    endtask

    task automatic t_lock;
        setup(longint'(1) << 22, -(longint'(1) << 22), 0, 164, 3, 0);
        run_batch(5, 1'b0, 1'b1, "R9");
        // R1: second start during run ignored, R9: barrier write ignored
        run_batch(6, 1'b0, 1'b0, "R1");
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog all-R actual=timeout expected=completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fine();
        t_knock();
        t_coarse();
        t_trunc();
        t_lock();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule